// File: doc/BRIEF.md
# Register-Addressed I2C Transaction Sequencer

This block runs whole memory-style transactions on a 7-bit I2C target. It sits above a bit-level bus engine. It breaks each transaction into engine commands of four kinds: START, STOP, byte write and byte read. One command descriptor holds the kind (write, read or probe), the device address, a register address of zero to `ADDR_BYTES` bytes, a byte count, a fold mask and the restart style. Write data enters on a valid/ready byte stream. Read data leaves on a second valid/ready byte stream. A one-cycle result pulse reports the error flag, the presence flag and the data-byte NACK count.

The engine interface is a held request. `eng_cmd_valid` stays high with the same opcode and byte until the engine pulses `eng_done`. With that pulse the engine returns the acknowledge bit it sampled after a written byte, or the byte it received for a read. Opcodes are START=0, STOP=1, WRITE=2 and READ=3.

States: IDLE, START, DEV_WR, REG_ADDR, RE_STOP, RE_START, DEV_RD, RD_BYTE, RD_PUSH, WR_WAIT, WR_BYTE, STOP, FINISH.
- IDLE→START when a command is accepted.
- START→DEV_RD for a read with zero address length. Otherwise START→DEV_WR.
- DEV_WR→STOP on a NACK or for a probe. DEV_WR→REG_ADDR when the address length is nonzero. DEV_WR→WR_WAIT or STOP for a write with no register address.
- REG_ADDR repeats once per address byte and goes to STOP on a NACK.
- After the last address byte, a write goes to WR_WAIT or STOP. A read goes to RE_START when repeated START is selected, or to RE_STOP→RE_START otherwise.
- RE_START→DEV_RD.
- DEV_RD→RD_BYTE, or →STOP if the count is zero.
- RD_BYTE→RD_PUSH.
- RD_PUSH→RD_BYTE, or →STOP after the last byte.
- WR_WAIT→WR_BYTE.
- WR_BYTE→WR_WAIT, or →STOP after the last byte.
- STOP→FINISH→IDLE.

Top module: `i2c_txn_seq`

## Requirements
- R1: `cmd_ready` is high only in IDLE. `busy` rises in the cycle after a command is accepted and stays high through the one-cycle `res_valid` pulse. `busy` is low in the cycle after that pulse.
- R2: A write issues START, then WRITE of {device,0}, then one WRITE per register-address byte with the most significant byte first, then one WRITE per data byte in stream order, then STOP.
- R3: If the {device,0} byte returns NACK (`eng_rx_nack`=1) in a read or write, the sequencer issues STOP next and reports `res_error`=1.
- R4: If any register-address byte returns NACK, no further address or data bytes are sent, STOP is issued and `res_error`=1.
- R5: A read with nonzero address length runs the address phase (START, {device,0}, address bytes). It then issues START alone when `cfg_rep_start`=1, or STOP then START when `cfg_rep_start`=0, and then WRITE of {device,1}.
- R6: A read with zero address length issues START followed directly by WRITE of {device,1}.
- R7: Each READ command carries `eng_cmd_nack`=0, except the last of the transaction, which carries 1. STOP follows the last READ. The acknowledge returned for the {device,1} byte does not change the sequence or the error flag.
- R8: On a write, a NACK on a data byte does not end the transfer. `res_fail_count` reports the number of NACKed data bytes, with `res_error`=0.
- R9: For reads and writes, the device address sent is `cmd_dev` ORed with (`cmd_reg` shifted right by 8×`cmd_len`) ANDed with `cmd_fold_mask`. This folded address is used in every device-address byte of the transaction.
- R10: A probe issues START, WRITE of {device,0} and STOP. It reports `res_present` = not NACK and `res_error`=0. `cmd_reg` and the fold mask have no effect on a probe.
- R11: A read byte is held on `rd_data` with `rd_valid` until `rd_ready`. A write byte is taken only on `wr_valid` with `wr_ready`. An engine command is held unchanged until `eng_done`.
- R12: After reset the block is idle: `cmd_ready`=1, `busy`=0, `eng_cmd_valid`=0, `rd_valid`=0, `wr_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command descriptor valid |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_kind | input | 2 | 0 write, 1 read, 2 probe |
| cmd_dev | input | 7 | Target device address |
| cmd_reg | input | 8*ADDR_BYTES | Register address |
| cmd_len | input | LEN_W | Register-address length in bytes |
| cmd_count | input | COUNT_W | Data byte count |
| cmd_fold_mask | input | 7 | Mask for overflow bits folded into the device address |
| cfg_rep_start | input | 1 | 1: repeated START before a read; 0: STOP then START |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Sequencer takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Engine command request, held until done |
| eng_cmd_op | output | 2 | START=0, STOP=1, WRITE=2, READ=3 |
| eng_cmd_byte | output | 8 | Byte to write |
| eng_cmd_nack | output | 1 | Acknowledge level to send after a READ (1 = NACK) |
| eng_done | input | 1 | Engine finished the current command |
| eng_rx_nack | input | 1 | Sampled acknowledge after a WRITE (1 = NACK) |
| eng_rx_byte | input | 8 | Byte received by a READ |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle result pulse |
| res_error | output | 1 | Address or register-address NACK |
| res_present | output | 1 | Probe result |
| res_fail_count | output | COUNT_W | NACKed data bytes of a write |

## Verification
The bench drives writes of one, two, three and four address bytes, clean and with NACK patterns on the device byte, a middle address byte and alternating data bytes. These cases separate abort-on-address from count-and-continue on data. Reads use both restart styles and zero address length, so a missing or extra STOP shows up as an out-of-order engine command. The {device,1} acknowledge is driven as NACK to show that it is ignored. Fold cases put nonzero bits above the address length, and a probe carries a busy register address and mask to show that folding is skipped there. Backpressure on both byte streams shows that no byte is dropped or repeated.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        TXN_WRITE = 2'd0,
        TXN_READ  = 2'd1,
        TXN_PROBE = 2'd2
    } txn_kind_e;

endpackage

// File: rtl/i2c_seq_fold.sv
// Folds register-address bits above the configured length into the device address.
module i2c_seq_fold #(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input  logic [6:0]              dev,
    input  logic [8*ADDR_BYTES-1:0] reg_addr,
    input  logic [LEN_W-1:0]        len,
    input  logic [6:0]              mask,
    input  logic                    en,
    output logic [6:0]              dev_eff
);
    localparam int WIDE_W = 8*ADDR_BYTES + 8;

    logic [WIDE_W-1:0] upper;

    assign upper   = {8'h00, reg_addr} >> {len, 3'b000};
    assign dev_eff = en ? (dev | (upper[6:0] & mask)) : dev;
endmodule

// File: rtl/i2c_seq_regsel.sv
// Picks one byte of the register address by index.
module i2c_seq_regsel #(
    parameter int ADDR_BYTES = 4,
    parameter int IDX_W      = 2
) (
    input  logic [8*ADDR_BYTES-1:0] reg_addr,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              byte_out
);
    always_comb begin
        byte_out = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx == IDX_W'(i)) byte_out = reg_addr[8*i +: 8];
        end
    end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int COUNT_W    = 8,
    localparam int LEN_W     = $clog2(ADDR_BYTES + 1),
    localparam int RA_W      = 8 * ADDR_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_kind,
    input  logic [6:0]         cmd_dev,
    input  logic [RA_W-1:0]    cmd_reg,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [COUNT_W-1:0] cmd_count,
    input  logic [6:0]         cmd_fold_mask,
    input  logic               cfg_rep_start,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [7:0]         wr_data,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [7:0]         rd_data,
    output logic               eng_cmd_valid,
    output logic [1:0]         eng_cmd_op,
    output logic [7:0]         eng_cmd_byte,
    output logic               eng_cmd_nack,
    input  logic               eng_done,
    input  logic               eng_rx_nack,
    input  logic [7:0]         eng_rx_byte,
    output logic               busy,
    output logic               res_valid,
    output logic               res_error,
    output logic               res_present,
    output logic [COUNT_W-1:0] res_fail_count
);
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEV_WR, S_REG_ADDR, S_RE_STOP, S_RE_START,
        S_DEV_RD, S_RD_BYTE, S_RD_PUSH, S_WR_WAIT, S_WR_BYTE, S_STOP, S_FINISH
    } state_e;

    state_e state_q, state_d;

    logic [1:0]         kind_q;
    logic [6:0]         dev_q, mask_q;
    logic [RA_W-1:0]    reg_q;
    logic [LEN_W-1:0]   len_q;
    logic [COUNT_W-1:0] cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic               rep_q;
    logic [7:0]         wbuf_q, rbuf_q;
    logic               err_q, present_q;
    logic [COUNT_W-1:0] fails_q;

    logic       is_read, is_write, is_probe, last_cnt;
    logic [6:0] dev_eff;
    logic [7:0] reg_byte;

    assign is_read  = (kind_q == TXN_READ);
    assign is_write = (kind_q == TXN_WRITE);
    assign is_probe = !(is_read || is_write);
    assign last_cnt = (cnt_q == COUNT_W'(1));

    i2c_seq_fold #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_fold (
        .dev      (dev_q),
        .reg_addr (reg_q),
        .len      (len_q),
        .mask     (mask_q),
        .en       (!is_probe),
        .dev_eff  (dev_eff)
    );

    i2c_seq_regsel #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_regsel (
        .reg_addr (reg_q),
        .idx      (idx_q),
        .byte_out (reg_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cmd_valid) state_d = S_START;
            S_START:    if (eng_done) state_d = (is_read && len_q == '0) ? S_DEV_RD : S_DEV_WR;
            S_DEV_WR:   if (eng_done) begin
                            if (eng_rx_nack || is_probe) state_d = S_STOP;
                            else if (len_q != '0)        state_d = S_REG_ADDR;
                            else                         state_d = (cnt_q != '0) ? S_WR_WAIT : S_STOP;
                        end
            S_REG_ADDR: if (eng_done) begin
                            if (eng_rx_nack)         state_d = S_STOP;
                            else if (idx_q != '0)    state_d = S_REG_ADDR;
                            else if (is_read)        state_d = rep_q ? S_RE_START : S_RE_STOP;
                            else                     state_d = (cnt_q != '0) ? S_WR_WAIT : S_STOP;
                        end
            S_RE_STOP:  if (eng_done) state_d = S_RE_START;
            S_RE_START: if (eng_done) state_d = S_DEV_RD;
            S_DEV_RD:   if (eng_done) state_d = (cnt_q != '0) ? S_RD_BYTE : S_STOP;
            S_RD_BYTE:  if (eng_done) state_d = S_RD_PUSH;
            S_RD_PUSH:  if (rd_ready) state_d = last_cnt ? S_STOP : S_RD_BYTE;
            S_WR_WAIT:  if (wr_valid) state_d = S_WR_BYTE;
            S_WR_BYTE:  if (eng_done) state_d = last_cnt ? S_STOP : S_WR_WAIT;
            S_STOP:     if (eng_done) state_d = S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0; dev_q <= '0; mask_q <= '0; reg_q <= '0; len_q <= '0;
            cnt_q <= '0; idx_q <= '0; rep_q <= 1'b0; wbuf_q <= '0; rbuf_q <= '0;
            err_q <= 1'b0; present_q <= 1'b0; fails_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (cmd_valid) begin
                    kind_q <= cmd_kind; dev_q <= cmd_dev; mask_q <= cmd_fold_mask;
                    reg_q <= cmd_reg; len_q <= cmd_len; cnt_q <= cmd_count;
                    rep_q <= cfg_rep_start; err_q <= 1'b0; present_q <= 1'b0;
                    fails_q <= '0;
                end
                S_DEV_WR: if (eng_done) begin
                    if (is_probe)         present_q <= !eng_rx_nack;
                    else if (eng_rx_nack) err_q <= 1'b1;
                    idx_q <= IDX_W'(len_q - LEN_W'(1));
                end
                S_REG_ADDR: if (eng_done) begin
                    if (eng_rx_nack) err_q <= 1'b1;
                    else             idx_q <= idx_q - IDX_W'(1);
                end
                S_RD_BYTE: if (eng_done) rbuf_q <= eng_rx_byte;
                S_RD_PUSH: if (rd_ready) cnt_q <= cnt_q - COUNT_W'(1);
                S_WR_WAIT: if (wr_valid) wbuf_q <= wr_data;
                S_WR_BYTE: if (eng_done) begin
                    if (eng_rx_nack) fails_q <= fails_q + COUNT_W'(1);
                    cnt_q <= cnt_q - COUNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        eng_cmd_valid = 1'b0;
        eng_cmd_op    = OP_START;
        eng_cmd_byte  = 8'h00;
        eng_cmd_nack  = 1'b0;
        unique case (state_q)
            S_START, S_RE_START: begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_START; end
            S_RE_STOP, S_STOP:   begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_STOP;  end
            S_DEV_WR:   begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_WRITE; eng_cmd_byte = {dev_eff, 1'b0}; end
            S_DEV_RD:   begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_WRITE; eng_cmd_byte = {dev_eff, 1'b1}; end
            S_REG_ADDR: begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_WRITE; eng_cmd_byte = reg_byte; end
            S_WR_BYTE:  begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_WRITE; eng_cmd_byte = wbuf_q; end
            S_RD_BYTE:  begin eng_cmd_valid = 1'b1; eng_cmd_op = OP_READ;  eng_cmd_nack = last_cnt; end
            default: ;
        endcase
        cmd_ready      = (state_q == S_IDLE);
        busy           = (state_q != S_IDLE);
        wr_ready       = (state_q == S_WR_WAIT);
        rd_valid       = (state_q == S_RD_PUSH);
        rd_data        = rbuf_q;
        res_valid      = (state_q == S_FINISH);
        res_error      = err_q;
        res_present    = present_q;
        res_fail_count = fails_q;
    end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
    import i2c_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       busy,
    input logic       res_valid,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       eng_cmd_valid,
    input logic [1:0] eng_cmd_op,
    input logic [7:0] eng_cmd_byte,
    input logic       eng_cmd_nack,
    input logic       eng_done
);
    logic last_was_stop;

    always_ff @(posedge clk) begin
        if (!rst_n)                        last_was_stop <= 1'b0;
        else if (eng_cmd_valid && eng_done) last_was_stop <= (eng_cmd_op == OP_STOP);
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy && !cmd_ready);

    assert_result_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !busy && cmd_ready);

    assert_bus_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> last_was_stop);

    assert_eng_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid && !eng_done |=> eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_byte));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    assert_wr_no_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !eng_cmd_valid && !rd_valid);

    assert_nack_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_nack |-> eng_cmd_valid && eng_cmd_op == OP_READ);
endmodule

bind i2c_txn_seq i2c_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .busy          (busy),
    .res_valid     (res_valid),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_data       (rd_data),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_op    (eng_cmd_op),
    .eng_cmd_byte  (eng_cmd_byte),
    .eng_cmd_nack  (eng_cmd_nack),
    .eng_done      (eng_done)
);

// File: tb/i2c_txn_seq_bench.sv
module i2c_txn_seq_bench;
    import i2c_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = '0;
    logic [6:0]  cmd_dev = '0;
    logic [31:0] cmd_reg = '0;
    logic [2:0]  cmd_len = '0;
    logic [7:0]  cmd_count = '0;
    logic [6:0]  cmd_fold_mask = '0;
    logic        cfg_rep_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        eng_cmd_valid;
    logic [1:0]  eng_cmd_op;
    logic [7:0]  eng_cmd_byte;
    logic        eng_cmd_nack;
    logic        eng_done = 1'b0;
    logic        eng_rx_nack = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        busy, res_valid, res_error, res_present;
    logic [7:0]  res_fail_count;

    always #4 clk = ~clk;

    i2c_txn_seq u_i2c_txn_seq (.*);

    int n_cmp = 0;
    int n_bad = 0;

    // Expected engine command stream and engine responses
    logic [1:0] q_op[$];
    logic [7:0] q_byte[$];
    logic       q_nack[$];
    string      q_tag[$];
    logic       ack_plan[$];
    logic [7:0] rd_src[$];
    logic [7:0] rd_exp[$];
    logic [7:0] wr_src[$];

    bit stall_mode = 0;
    bit got_res = 0;
    logic g_err, g_pres;
    logic [7:0] g_fails;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural engine: accepts a held request, answers after a short delay
    logic       e_run = 1'b0;
    int         e_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0; e_run <= 1'b0;
        end else if (eng_done) begin
            eng_done <= 1'b0;
        end else if (e_run) begin
            if (e_cnt == 0) begin eng_done <= 1'b1; e_run <= 1'b0; end
            else e_cnt <= e_cnt - 1;
        end else if (eng_cmd_valid) begin
            if (q_op.size() == 0) begin
                check(0, "R2", "unexpected engine command op", eng_cmd_op, 0);
            end else begin
                logic [1:0] xo; logic [7:0] xb; logic xn; string xt;
                xo = q_op.pop_front(); xb = q_byte.pop_front();
                xn = q_nack.pop_front(); xt = q_tag.pop_front();
                check(eng_cmd_op == xo, xt, "engine op", eng_cmd_op, xo);
                if (xo == OP_WRITE) check(eng_cmd_byte == xb, xt, "engine byte", eng_cmd_byte, xb);
                if (xo == OP_READ)  check(eng_cmd_nack == xn, "R7", "read ack level", eng_cmd_nack, xn);
            end
            if (eng_cmd_op == OP_WRITE) eng_rx_nack <= (ack_plan.size() != 0) ? ack_plan.pop_front() : 1'b0;
            if (eng_cmd_op == OP_READ)  eng_rx_byte <= (rd_src.size() != 0) ? rd_src.pop_front() : 8'h00;
            e_run <= 1'b1;
            e_cnt <= 1;
        end
    end

    // Write stream source
    bit wr_taken = 0;
    int phase = 0;
    always @(negedge clk) begin
        phase++;
        if (wr_taken) void'(wr_src.pop_front());
        wr_valid = (wr_src.size() != 0) && (!stall_mode || phase[0]);
        wr_data  = (wr_src.size() != 0) ? wr_src[0] : 8'h00;
        wr_taken = wr_valid && wr_ready;
    end

    // Read stream sink
    always @(negedge clk) begin
        rd_ready = !stall_mode || phase[1];
        if (rd_valid && rd_ready) begin
            if (rd_exp.size() == 0) check(0, "R11", "extra read byte", rd_data, 0);
            else begin
                logic [7:0] x; x = rd_exp.pop_front();
                check(rd_data == x, "R11", "read byte", rd_data, x);
            end
        end
    end

    always @(negedge clk) begin
        if (res_valid) begin
            got_res = 1; g_err = res_error; g_pres = res_present; g_fails = res_fail_count;
        end
    end

    task automatic expect_op(input logic [1:0] op, input logic [7:0] b, input logic n, input string tag);
        q_op.push_back(op); q_byte.push_back(b); q_nack.push_back(n); q_tag.push_back(tag);
    endtask

    // kind: 0 write, 1 read, 2 probe; regnack: index of NACKed address byte or -1
    task automatic run(input string name, input int kind, input logic [6:0] dev, input logic [31:0] ra,
                       input int len, input int cnt, input logic [6:0] mask, input bit rep,
                       input bit devnack, input int regnack, input logic [15:0] dnack, input bit stall);
        logic [39:0] up;
        logic [6:0]  fd;
        bit          x_err, x_pres, stop_now;
        int          x_fails;
        x_err = 0; x_pres = 0; x_fails = 0; stop_now = 0;
        up = {8'h00, ra} >> (8*len);
        fd = (kind == 2) ? dev : (dev | (up[6:0] & mask));
        expect_op(OP_START, 8'h00, 0, "R2");
        if (kind == 1 && len == 0) begin
            // R6: direct read address byte, its acknowledge is NACK and must be ignored (R7)
            expect_op(OP_WRITE, {fd, 1'b1}, 0, "R6"); ack_plan.push_back(1'b1);
        end else begin
            expect_op(OP_WRITE, {fd, 1'b0}, 0, (mask != 0) ? "R9" : "R2"); ack_plan.push_back(devnack);
            if (devnack) begin x_err = (kind != 2); stop_now = 1; end
            else if (kind == 2) begin x_pres = 1; stop_now = 1; end
            for (int i = 0; i < len && !stop_now; i++) begin
                logic [7:0] b;
                b = 8'((ra >> (8*(len-1-i))) & 32'hFF);
                expect_op(OP_WRITE, b, 0, (regnack >= 0) ? "R4" : "R2");
                ack_plan.push_back(i == regnack);
                if (i == regnack) begin x_err = 1; stop_now = 1; end
            end
            if (!stop_now && kind == 0) begin
                for (int j = 0; j < cnt; j++) begin
                    logic [7:0] w; w = 8'(8'h3C + j*8'h25);
                    wr_src.push_back(w);
                    expect_op(OP_WRITE, w, 0, "R8");
                    ack_plan.push_back(dnack[j]);
                    if (dnack[j]) x_fails++;
                end
            end
            if (!stop_now && kind == 1) begin
                if (!rep) expect_op(OP_STOP, 8'h00, 0, "R5");
                expect_op(OP_START, 8'h00, 0, "R5");
                expect_op(OP_WRITE, {fd, 1'b1}, 0, (mask != 0) ? "R9" : "R5");
                ack_plan.push_back(1'b1);
            end
        end
        if (!stop_now && kind == 1) begin
            for (int j = 0; j < cnt; j++) begin
                logic [7:0] r; r = 8'(8'hC1 ^ (j*8'h17));
                rd_src.push_back(r); rd_exp.push_back(r);
                expect_op(OP_READ, 8'h00, (j == cnt-1), "R7");
            end
        end
        expect_op(OP_STOP, 8'h00, 0, devnack ? "R3" : "R2");

        stall_mode = stall;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", {name, " ready before command"}, cmd_ready, 1);
        cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_dev = dev; cmd_reg = ra;
        cmd_len = 3'(len); cmd_count = 8'(cnt); cmd_fold_mask = mask; cfg_rep_start = rep;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R1", {name, " busy after accept"}, busy, 1);
        for (int t = 0; t < 3000 && !got_res; t++) @(negedge clk);
        check(got_res == 1, "R1", {name, " result pulse"}, got_res, 1);
        check(g_err == x_err, devnack ? "R3" : "R4", {name, " error flag"}, g_err, x_err);
        check(g_pres == x_pres, "R10", {name, " present flag"}, g_pres, x_pres);
        check(g_fails == 8'(x_fails), "R8", {name, " fail count"}, g_fails, x_fails);
        @(negedge clk);
        check(busy == 1'b0 && cmd_ready == 1'b1, "R1", {name, " idle after result"}, busy, 0);
        check(q_op.size() == 0, "R2", {name, " engine commands left"}, q_op.size(), 0);
        check(rd_exp.size() == 0 && wr_src.size() == 0, "R11", {name, " stream bytes left"},
              rd_exp.size() + wr_src.size(), 0);
        q_op.delete(); q_byte.delete(); q_nack.delete(); q_tag.delete();
        ack_plan.delete(); rd_src.delete(); rd_exp.delete(); wr_src.delete();
        got_res = 0;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12 reset state
        check(cmd_ready == 1 && busy == 0, "R12", "idle in reset", {cmd_ready, busy}, 2'b10);
        check(eng_cmd_valid == 0 && rd_valid == 0 && wr_ready == 0, "R12", "quiet outputs in reset",
              {eng_cmd_valid, rd_valid, wr_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1 && busy == 0 && eng_cmd_valid == 0, "R12", "idle after reset",
              {cmd_ready, busy, eng_cmd_valid}, 3'b100);

        run("wr2",      0, 7'h50, 32'h0000_1234, 2, 3, 7'h00, 0, 0, -1, 16'h0000, 0);
        run("wr4",      0, 7'h2A, 32'hDEAD_BEEF, 4, 2, 7'h00, 0, 0, -1, 16'h0000, 0);
        run("wr_dnack", 0, 7'h11, 32'h0000_0077, 1, 4, 7'h00, 0, 0, -1, 16'h000A, 1);
        run("wr0",      0, 7'h33, 32'h0000_0000, 0, 2, 7'h00, 0, 0, -1, 16'h0001, 0);
        run("wr_devn",  0, 7'h44, 32'h0000_0102, 2, 2, 7'h00, 0, 1, -1, 16'h0000, 0);
        run("wr_regn",  0, 7'h45, 32'h00AB_CDEF, 3, 2, 7'h00, 0, 0, 1, 16'h0000, 0);
        run("rd_stop",  1, 7'h50, 32'h0000_0A0B, 2, 3, 7'h00, 0, 0, -1, 16'h0000, 1);
        run("rd_rep",   1, 7'h51, 32'h0000_0099, 1, 2, 7'h00, 1, 0, -1, 16'h0000, 0);
        run("rd_len0",  1, 7'h3B, 32'h0000_0000, 0, 2, 7'h00, 0, 0, -1, 16'h0000, 1);
        run("rd_devn",  1, 7'h3C, 32'h0000_0055, 1, 2, 7'h00, 0, 1, -1, 16'h0000, 0);
        run("rd_regn",  1, 7'h3D, 32'h0000_6655, 2, 2, 7'h00, 1, 0, 0, 16'h0000, 0);
        run("wr_fold",  0, 7'h50, 32'h0000_0345, 1, 1, 7'h03, 0, 0, -1, 16'h0000, 0);
        run("rd_fold",  1, 7'h50, 32'h0701_2233, 2, 1, 7'h07, 1, 0, -1, 16'h0000, 0);
        run("pr_ack",   2, 7'h68, 32'hFFFF_FFFF, 0, 0, 7'h7F, 0, 0, -1, 16'h0000, 0);
        run("pr_nack",  2, 7'h69, 32'h1234_5678, 2, 3, 7'h7F, 0, 1, -1, 16'h0000, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule